// File: doc/BRIEF.md
# Convolutional Byte Interleaver

This block takes a stream of error-protected packets of 204 bytes and spreads their bytes over twelve parallel delay branches. A burst of corrupted bytes on the channel then lands in many different packets after deinterleaving. The block accepts one byte per valid cycle. An input selector steps to the next branch on every valid byte. Branch 0 passes its byte straight through. Branch j delays its bytes by 17·j of its own writes. An output selector always reads the same branch the input selector wrote, so the output stream carries one byte per valid input byte.

A packet start is flagged with a sync marker on its first byte. The marker forces that byte onto branch 0 and restarts the branch sequence. Packet sync bytes therefore leave the block undelayed, in their original position. A second effect is that the selector recovers by itself if it ever drifts out of step with the packet boundaries. The delay lines advance only on valid bytes written to their own branch, so idle cycles have no effect on the interleaving pattern.

Top module: `byte_interleaver`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, valid_o, sync_o and data_o are all 0.
- R2: valid_o equals valid_i of the previous cycle. sync_o equals (valid_i AND sync_i) of the previous cycle.
- R3: A byte written to branch 0 appears on data_o one cycle later, unchanged.
- R4: A byte written to branch j (1..11) appears on data_o in the cycle after the 17·j-th later write to branch j.
- R5: Without a sync marker, each valid byte goes to the branch that follows the previous valid byte's branch. The sequence runs 0, 1, …, 11 and then wraps to 0.
- R6: A valid byte that carries sync_i goes to branch 0, whatever the current selector position. The next valid byte then goes to branch 1.
- R7: In a cycle with valid_i low, no delay line shifts and the selector does not move. The following cycle has valid_o low and data_o unchanged.
- R8: After reset every delay cell holds 0x00. The first 17·j reads from branch j therefore return 0x00.
- R9: sync_i asserted while valid_i is low has no effect on the selector or on sync_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input byte qualifier |
| sync_i | input | 1 | Marks the first byte of a packet |
| data_i | input | 8 | Input byte |
| valid_o | output | 1 | Output byte qualifier |
| sync_o | output | 1 | Marks an output byte taken from a sync input byte |
| data_o | output | 8 | Interleaved output byte |

## Verification
The assertions assume that inputs are driven to known values from the first clock edge after reset. They also assume that sync_i is only meaningful together with valid_i. The stimulus respects both assumptions: every input is held at 0 during reset and changes only on the falling edge. It sends whole 204-byte packets with sync on the first byte, mixed with random idle gaps. Two deliberate departures are included: a sync marker placed in the middle of a packet, and sync pulses raised without valid. Both exercise the forced return to branch 0 and the rule that marker pulses without valid are ignored.

// File: rtl/il_pkg.sv
package il_pkg;
  localparam int unsigned IL_BRANCHES  = 12;
  localparam int unsigned IL_FRAME_LEN = 204;
  localparam int unsigned IL_DATA_W    = 8;
endpackage

// File: rtl/il_selector.sv
module il_selector #(
  parameter int unsigned BRANCHES = 12,
  localparam int unsigned SEL_W = $clog2(BRANCHES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sync_i,
  output logic [SEL_W-1:0] sel_o
);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(BRANCHES - 1);
  logic [SEL_W-1:0] pos_q;

  // sync forces branch 0 in the same cycle
  assign sel_o = sync_i ? '0 : pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pos_q <= '0;
    else if (valid_i) pos_q <= (sel_o == LAST) ? '0 : sel_o + 1'b1;
  end
endmodule

// File: rtl/il_delay_line.sv
module il_delay_line #(
  parameter int unsigned DEPTH  = 17,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o
);
  if (DEPTH == 0) begin : g_pass
    assign data_o = data_i;
  end else begin : g_fifo
    logic [DATA_W-1:0] cell_q [DEPTH];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int k = 0; k < DEPTH; k++) cell_q[k] <= '0;
      end else if (shift_i) begin
        cell_q[0] <= data_i;
        for (int k = 1; k < DEPTH; k++) cell_q[k] <= cell_q[k-1];
      end
    end
    // oldest cell is read in the same cycle it is displaced
    assign data_o = cell_q[DEPTH-1];
  end
endmodule

// File: rtl/byte_interleaver.sv
module byte_interleaver
  import il_pkg::*;
#(
  parameter int unsigned BRANCHES  = IL_BRANCHES,
  parameter int unsigned FRAME_LEN = IL_FRAME_LEN,
  parameter int unsigned DATA_W    = IL_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              sync_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic              sync_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned UNIT  = FRAME_LEN / BRANCHES;
  localparam int unsigned SEL_W = $clog2(BRANCHES);

  logic [SEL_W-1:0]  sel;
  logic [DATA_W-1:0] br_out [BRANCHES];

  il_selector #(.BRANCHES(BRANCHES)) u_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .sync_i (sync_i),
    .sel_o  (sel)
  );

  for (genvar j = 0; j < BRANCHES; j++) begin : g_branch
    logic shift;
    assign shift = valid_i && (sel == SEL_W'(j));
    il_delay_line #(.DEPTH(UNIT * j), .DATA_W(DATA_W)) u_line (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .shift_i(shift),
      .data_i (data_i),
      .data_o (br_out[j])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sync_o  <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      sync_o  <= valid_i & sync_i;
      if (valid_i) data_o <= br_out[sel];
    end
  end
endmodule

// File: rtl/il_checker.sv
module il_checker #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              sync_i,
  input logic [DATA_W-1:0] data_i,
  input logic              valid_o,
  input logic              sync_o,
  input logic [DATA_W-1:0] data_o
);
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |-> (!valid_o && !sync_o && data_o == '0));

  // R2
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    valid_o == $past(valid_i));

  // R2
  sync_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> valid_o);

  // R3
  sync_passthru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    sync_o |-> data_o == $past(data_i));

  // R6
  sync_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    $past(valid_i && sync_i) |-> sync_o);

  // R7
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    !$past(valid_i) |-> ($stable(data_o) && !valid_o));

  // R9
  lone_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    !$past(valid_i) |-> !sync_o);
endmodule

bind byte_interleaver il_checker #(.DATA_W(DATA_W)) u_il_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .sync_i (sync_i),
  .data_i (data_i),
  .valid_o(valid_o),
  .sync_o (sync_o),
  .data_o (data_o)
);

// File: tb/tb_byte_interleaver.sv
module tb_byte_interleaver;
  localparam int NB = 12;
  localparam int UNIT = 17;
  localparam int PKT = 204;

  logic clk = 0, rst_n = 0, vi = 0, si = 0;
  logic [7:0] di = 0;
  logic vo, so;
  logic [7:0] dout;

  always #10 clk = ~clk;

  byte_interleaver dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vi), .sync_i(si), .data_i(di),
    .valid_o(vo), .sync_o(so), .data_o(dout)
  );

  int total = 0, bad = 0, cycles = 0, pos = 0;
  bit done = 0;
  logic [7:0] q [NB][$];
  logic [7:0] exp_d = 0;
  logic exp_v = 0, exp_s = 0;
  string tag = "R1";

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // called at negedge: drive, model, wait one edge, compare
  task automatic step(bit v, bit s, logic [7:0] d);
    int sel;
    vi = v; si = s; di = d;
    exp_v = v; exp_s = v & s;
    if (v) begin
      sel = s ? 0 : pos;
      if (sel == 0) exp_d = d;
      else begin
        q[sel].push_back(d);
        exp_d = q[sel].pop_front();
      end
      pos = (sel + 1) % NB;
    end
    @(posedge clk); #2;
    chk("R2", int'(vo), int'(exp_v));
    chk("R2", int'(so), int'(exp_s));
    chk(tag, int'(dout), int'(exp_d));
    @(negedge clk);
  endtask

  task automatic packet(int gap_pct);
    for (int b = 0; b < PKT; b++) begin
      while (gap_pct > 0 && ($urandom % 100) < gap_pct) step(0, $urandom % 2, 8'($urandom));
      step(1, b == 0, 8'($urandom));
    end
  endtask

  initial begin
    for (int j = 0; j < NB; j++)
      for (int k = 0; k < UNIT * j; k++) q[j].push_back(8'h00);
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1", int'(vo), 0); chk("R1", int'(so), 0); chk("R1", int'(dout), 0);
    rst_n = 1;
    @(posedge clk); #2;
    chk("R1", int'(vo), 0); chk("R1", int'(dout), 0);
    @(negedge clk);
    // R8: initial zeros surface from delayed branches; R3 sync bytes direct
    tag = "R8";
    packet(0);
    packet(0);
    // R4/R5: steady stream long enough to flush every branch
    tag = "R4";
    for (int p = 0; p < 12; p++) packet(0);
    // R7: idle gaps (sync toggles while idle, R9)
    tag = "R7";
    for (int p = 0; p < 3; p++) packet(30);
    // R6: resync in mid packet
    tag = "R6";
    for (int b = 0; b < 57; b++) step(1, b == 0, 8'($urandom));
    step(1, 1, 8'hB8);
    for (int b = 0; b < 203; b++) step(1, 0, 8'($urandom));
    // R9: lone sync pulses must not move the selector
    tag = "R9";
    for (int b = 0; b < 5; b++) step(1, b == 0, 8'($urandom));
    step(0, 1, 8'h55);
    step(0, 1, 8'hAA);
    for (int b = 0; b < 300; b++) step(1, 0, 8'($urandom));
    // R5: steady traffic tail
    tag = "R5";
    for (int p = 0; p < 2; p++) packet(0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=finish", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule